// File: doc/BRIEF.md
# Radix Page Table Walker

This block translates a 64-bit effective address into a real address by walking a radix tree of page tables held in memory. A walk begins from two values: the process-table base register and the process ID. The walker first reads one process-table doubleword and decodes the tree size, the root directory size and the root base from it. It then checks that the effective address lies inside the tree's segment. After that it reads one directory entry per level until it reaches a leaf. For the leaf it checks access permission and the reference/change bits. The walk ends with a one-cycle `done` pulse that carries either the real address or exactly one fault flag.

All memory traffic goes through a request/acknowledge port. The walker raises `mem_req` with a doubleword address. The memory answers with `mem_ack` and `mem_data` in one cycle. Index bits are merged into each base address with a masked OR, not an addition. Each level's size is checked against fixed bounds and against the address bits that are still unresolved.

The controller has four states. `ST_IDLE` waits for `start`. `ST_TBL` holds the process-table read. `ST_DIR` holds one directory read per level. `ST_DONE` produces the done pulse. The transitions are:
- start-accept: `ST_IDLE` to `ST_TBL`.
- root-accepted: `ST_TBL` to `ST_DIR`.
- root-fault: `ST_TBL` to `ST_DONE`.
- descend: `ST_DIR` to `ST_DIR`.
- leaf-or-fault: `ST_DIR` to `ST_DONE`.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `radix_walk`

## Requirements
- R1: The process-table read address is {8 zero bits, ptbase[55:36], (ptbase[35:12] & ~m) | (epid[31:8] & m), epid[7:0], 4 zero bits}, where m holds the low ptbase[4:0] bits set (24-bit field) and epid is the effective PID.
- R2: When ea[63] is 1, the effective PID is zero; otherwise it is `pid`.
- R3: The process-table entry gives the tree-size code rts = {entry[62:61], entry[7:5]}, so the tree spans rts+31 address bits. If ea[63] differs from ea[62], or if any of ea[61:31] is set outside the low rts bits, the walk ends with `err_seg`.
- R4: The root size is entry[4:0]. If it is below 5, above 16, or above rts+19, the walk ends with `err_badtree`. Otherwise the root base is {entry[55:8], 8 zero bits} and the remaining shift becomes rts+19 minus the root size.
- R5: A directory read address is {8 zero bits, base[55:19], (base[18:3] & ~k) | (idx & k), 3 zero bits}. Here idx is the low 16 bits of ea[63:12] shifted right by the remaining shift, and k holds the low level-size bits set.
- R6: A valid non-leaf entry (bit 63 set, bit 62 clear) gives the next base {entry[55:8], 8 zero bits} and the next size entry[4:0]. That size gets the R4 bounds with the remaining shift as the limit. A failure ends with `err_badtree`. On success the remaining shift drops by the size and the next level is read.
- R7: A directory or leaf entry with bit 63 clear ends the walk with `err_invalid`.
- R8: A leaf (bits 63 and 62 set) passes the permission check only when `priv` is 1 or leaf bit 3 is 0. In addition, a data access needs bit 1 set, or bit 2 set together with `store` at 0. An instruction fetch needs bit 0 set and bit 5 clear. A failed check gives `err_perm`.
- R9: The reference/change check passes when bit 8 is set and either bit 7 is set or `store` is 0. A failure gives `err_rc` only when the permission check passed.
- R10: On success the real address is {8 zero bits, (leaf[55:12] & ~f) | (ea[55:12] & f), leaf[11:0]}, where f holds the low remaining-shift bits set.
- R11: `done` is high for exactly one cycle, the cycle after the last acknowledged read. At most one flag is set during it. The flags and `real_addr` are zero outside it, and `real_addr` is zero on a fault.
- R12: A `start` raised while a walk is in progress has no effect on that walk.
- R13: Each read holds `mem_req` and a stable `mem_addr` until acknowledged. A walk makes one read for the process table and one read per level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| ea | input | 64 | Effective address to translate |
| pid | input | 32 | Process ID register |
| ptbase | input | 64 | Process-table base register; bits 4:0 are the table size code |
| priv | input | 1 | Privileged access |
| ifetch | input | 1 | Instruction fetch (0 = data access) |
| store | input | 1 | Store access |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 64 | Doubleword read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_data | input | 64 | Read data |
| done | output | 1 | Walk finished (one-cycle pulse) |
| real_addr | output | 64 | Translated real address, valid with done |
| err_seg | output | 1 | Segment fault |
| err_badtree | output | 1 | Bad tree level size |
| err_invalid | output | 1 | Invalid entry |
| err_perm | output | 1 | Permission fault |
| err_rc | output | 1 | Reference/change fault |

## Verification
Every result is due in the cycle after the edge that takes the final acknowledge. The bench's memory model records the cycle in which it raised each acknowledge. For each walk the bench checks that `done` appears exactly one cycle later and has dropped by the next cycle. It also counts the reads served, which tests R13, and it checks the flags and address only in the `done` cycle. The permission and reference/change rules are swept over every combination of the seven relevant leaf bits, combined with every combination of privileged, fetch and store.

// File: rtl/rw_pkg.sv
package rw_pkg;
    localparam int VA_W     = 64;
    localparam int PID_W    = 32;
    localparam int SHIFT_W  = 6;
    localparam int LSIZE_W  = 5;
    localparam int BASE_W   = 56;
    localparam int ROOT_ADD = 19;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TBL,
        ST_DIR,
        ST_DONE
    } walk_state_t;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_SEG,
        FLT_BADTREE,
        FLT_INVALID,
        FLT_PERM,
        FLT_RC
    } fault_t;
endpackage

// File: rtl/rw_level_check.sv
module rw_level_check #(
    parameter int MIN_BITS = 5,
    parameter int MAX_BITS = 16
) (
    input  logic [4:0] mbits,
    input  logic [5:0] limit,
    output logic       ok
);
    always_comb begin
        ok = (mbits >= 5'(MIN_BITS)) && (mbits <= 5'(MAX_BITS)) && ({1'b0, mbits} <= limit);
    end
endmodule

// File: rtl/rw_leaf_check.sv
module rw_leaf_check (
    input  logic [63:0] entry,
    input  logic        priv,
    input  logic        ifetch,
    input  logic        store,
    output logic        perm_ok,
    output logic        rc_ok
);
    logic access_ok;
    logic unused_leafbits;

    always_comb begin
        if (ifetch)
            access_ok = entry[0] & ~entry[5];
        else
            access_ok = entry[1] | (entry[2] & ~store);
        perm_ok = (priv | ~entry[3]) & access_ok;
        rc_ok   = entry[8] & (entry[7] | ~store);
    end

    assign unused_leafbits = ^{entry[63:9], entry[6], entry[4]};
endmodule

// File: rtl/rw_addr_gen.sv
module rw_addr_gen (
    input  logic [63:0] ptbase,
    input  logic [31:0] epid,
    input  logic [63:0] ea,
    input  logic [55:0] base,
    input  logic [5:0]  shift,
    input  logic [4:0]  msize,
    input  logic [63:0] leaf,
    output logic [63:0] prte_addr,
    output logic [63:0] pde_addr,
    output logic [63:0] real_addr
);
    logic [44:0] fmask;
    logic [16:0] kmask;
    logic [51:0] ea_sh;
    logic [23:0] m24;
    logic [15:0] k16;
    logic [43:0] f44;
    logic        unused_ag;

    always_comb begin
        fmask = (45'd1 << shift) - 45'd1;
        kmask = (17'd1 << msize) - 17'd1;
        ea_sh = ea[63:12] >> shift;
        m24   = fmask[23:0];
        k16   = kmask[15:0];
        f44   = fmask[43:0];
        prte_addr = {8'h00, ptbase[55:36], (ptbase[35:12] & ~m24) | (epid[31:8] & m24), epid[7:0], 4'h0};
        pde_addr  = {8'h00, base[55:19], (base[18:3] & ~k16) | (ea_sh[15:0] & k16), 3'b000};
        real_addr = {8'h00, (leaf[55:12] & ~f44) | (ea[55:12] & f44), leaf[11:0]};
    end

    assign unused_ag = ^{ptbase[63:56], ptbase[11:0], ea[11:0], base[2:0], leaf[63:56],
                         ea_sh[51:16], fmask[44], kmask[16]};
endmodule

// File: rtl/radix_walk.sv
module radix_walk
    import rw_pkg::*;
#(
    parameter int MIN_LEVEL_BITS = 5,
    parameter int MAX_LEVEL_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] ea,
    input  logic [31:0] pid,
    input  logic [63:0] ptbase,
    input  logic        priv,
    input  logic        ifetch,
    input  logic        store,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ack,
    input  logic [63:0] mem_data,
    output logic        done,
    output logic [63:0] real_addr,
    output logic        err_seg,
    output logic        err_badtree,
    output logic        err_invalid,
    output logic        err_perm,
    output logic        err_rc
);
    walk_state_t state_q, state_d;
    fault_t      fault_q, fault_d;
    logic [VA_W-1:0]    ea_q, ptbase_q, raddr_q, raddr_d;
    logic [PID_W-1:0]   epid_q;
    logic               priv_q, ifetch_q, store_q;
    logic [BASE_W-1:0]  base_q, base_d;
    logic [SHIFT_W-1:0] shift_q, shift_d;
    logic [LSIZE_W-1:0] msize_q, msize_d;

    logic [VA_W-1:0]    prte_addr, pde_addr, leaf_real;
    logic [LSIZE_W-1:0] rts, data_size;
    logic [SHIFT_W-1:0] root_limit;
    logic [31:0]        seg_mask;
    logic               seg_bad, root_ok, lvl_ok, perm_ok, rc_ok;
    logic               unused_top;

    rw_addr_gen u_addr (
        .ptbase(ptbase_q), .epid(epid_q), .ea(ea_q), .base(base_q),
        .shift(shift_q), .msize(msize_q), .leaf(mem_data),
        .prte_addr(prte_addr), .pde_addr(pde_addr), .real_addr(leaf_real)
    );

    rw_level_check #(.MIN_BITS(MIN_LEVEL_BITS), .MAX_BITS(MAX_LEVEL_BITS)) u_root_chk (
        .mbits(data_size), .limit(root_limit), .ok(root_ok)
    );

    rw_level_check #(.MIN_BITS(MIN_LEVEL_BITS), .MAX_BITS(MAX_LEVEL_BITS)) u_lvl_chk (
        .mbits(data_size), .limit(shift_q), .ok(lvl_ok)
    );

    rw_leaf_check u_leaf_chk (
        .entry(mem_data), .priv(priv_q), .ifetch(ifetch_q), .store(store_q),
        .perm_ok(perm_ok), .rc_ok(rc_ok)
    );

    // decode of the process-table entry and segment check
    always_comb begin
        rts        = {mem_data[62:61], mem_data[7:5]};
        data_size  = mem_data[4:0];
        root_limit = SHIFT_W'(rts) + SHIFT_W'(ROOT_ADD);
        seg_mask   = (32'd1 << rts) - 32'd1;
        seg_bad    = (ea_q[63] ^ ea_q[62]) | (|(ea_q[61:31] & ~seg_mask[30:0]));
    end

    // next-state and walk data
    always_comb begin
        state_d = state_q;
        fault_d = fault_q;
        raddr_d = raddr_q;
        base_d  = base_q;
        shift_d = shift_q;
        msize_d = msize_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_TBL;
                    fault_d = FLT_NONE;
                    raddr_d = '0;
                    shift_d = {1'b0, ptbase[4:0]};
                end
            end
            ST_TBL: begin
                if (mem_ack) begin
                    if (seg_bad) begin
                        fault_d = FLT_SEG;
                        state_d = ST_DONE;
                    end else if (!root_ok) begin
                        fault_d = FLT_BADTREE;
                        state_d = ST_DONE;
                    end else begin
                        base_d  = {mem_data[55:8], 8'h00};
                        shift_d = root_limit - SHIFT_W'(data_size);
                        msize_d = data_size;
                        state_d = ST_DIR;
                    end
                end
            end
            ST_DIR: begin
                if (mem_ack) begin
                    if (!mem_data[63]) begin
                        fault_d = FLT_INVALID;
                        state_d = ST_DONE;
                    end else if (mem_data[62]) begin
                        state_d = ST_DONE;
                        if (!perm_ok)
                            fault_d = FLT_PERM;
                        else if (!rc_ok)
                            fault_d = FLT_RC;
                        else
                            raddr_d = leaf_real;
                    end else if (!lvl_ok) begin
                        fault_d = FLT_BADTREE;
                        state_d = ST_DONE;
                    end else begin
                        base_d  = {mem_data[55:8], 8'h00};
                        shift_d = shift_q - SHIFT_W'(data_size);
                        msize_d = data_size;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fault_q  <= FLT_NONE;
            raddr_q  <= '0;
            base_q   <= '0;
            shift_q  <= '0;
            msize_q  <= '0;
            ea_q     <= '0;
            ptbase_q <= '0;
            epid_q   <= '0;
            priv_q   <= 1'b0;
            ifetch_q <= 1'b0;
            store_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fault_q <= fault_d;
            raddr_q <= raddr_d;
            base_q  <= base_d;
            shift_q <= shift_d;
            msize_q <= msize_d;
            if (state_q == ST_IDLE && start) begin
                ea_q     <= ea;
                ptbase_q <= ptbase;
                epid_q   <= ea[63] ? '0 : pid;
                priv_q   <= priv;
                ifetch_q <= ifetch;
                store_q  <= store;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req     = (state_q == ST_TBL) || (state_q == ST_DIR);
        mem_addr    = (state_q == ST_TBL) ? prte_addr : pde_addr;
        done        = (state_q == ST_DONE);
        err_seg     = done && (fault_q == FLT_SEG);
        err_badtree = done && (fault_q == FLT_BADTREE);
        err_invalid = done && (fault_q == FLT_INVALID);
        err_perm    = done && (fault_q == FLT_PERM);
        err_rc      = done && (fault_q == FLT_RC);
        real_addr   = (done && fault_q == FLT_NONE) ? raddr_q : '0;
    end

    assign unused_top = ^{mem_data[60:56], seg_mask[31]};

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones({err_seg, err_badtree, err_invalid, err_perm, err_rc}) <= 1));

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(ea_q));

    assert_shift_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIR && mem_ack && state_d == ST_DIR) |=> (shift_q < $past(shift_q)));
endmodule

// File: tb/radix_walk_bench.sv
module radix_walk_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ea = '0;
    logic [31:0] pid = '0;
    logic [63:0] ptbase = '0;
    logic        priv = 1'b0, ifetch = 1'b0, store = 1'b0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_data = '0;
    logic        done;
    logic [63:0] real_addr;
    logic        err_seg, err_badtree, err_invalid, err_perm, err_rc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_cyc = 0;
    int reads = 0;

    logic [63:0] mem_img [logic [63:0]];

    radix_walk u_radix_walk (
        .clk(clk), .rst_n(rst_n), .start(start), .ea(ea), .pid(pid), .ptbase(ptbase),
        .priv(priv), .ifetch(ifetch), .store(store),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .done(done), .real_addr(real_addr),
        .err_seg(err_seg), .err_badtree(err_badtree), .err_invalid(err_invalid),
        .err_perm(err_perm), .err_rc(err_rc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model: one acknowledge per request, driven just after the edge
    always @(posedge clk) begin
        #1;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack  = 1'b1;
            mem_data = mem_img.exists(mem_addr) ? mem_img[mem_addr] : 64'h0;
            reads++;
            ack_cyc  = cyc;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // flag packing used by the bench: {seg, badtree, invalid, perm, rc}
    localparam logic [4:0] F_NONE = 5'b00000, F_SEG = 5'b10000, F_BAD = 5'b01000,
                           F_INV = 5'b00100, F_PERM = 5'b00010, F_RC = 5'b00001;

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] leaf_flags(input logic [63:0] lf, input logic pv, fe, st);
        logic pok, rok;
        pok = (pv || !lf[3]) && (fe ? (lf[0] && !lf[5]) : (lf[1] || (lf[2] && !st)));
        rok = lf[8] && (lf[7] || !st);
        if (!pok) return F_PERM;
        if (!rok) return F_RC;
        return F_NONE;
    endfunction

    function automatic logic [63:0] prte_at(input logic [63:0] ptb, input logic [31:0] ep);
        logic [23:0] m;
        m = 24'((64'd1 << ptb[4:0]) - 64'd1);
        return {8'h00, ptb[55:36], (ptb[35:12] & ~m) | (ep[31:8] & m), ep[7:0], 4'h0};
    endfunction

    // tree with rts code 3 (34-bit tree): root of 13 bits, second level of 9 bits
    task automatic build_tree(input logic [63:0] prte_a, input logic [63:0] root, input logic [63:0] l2,
                              input logic [63:0] va, input logic [63:0] leaf);
        mem_img[prte_a] = root | 64'h60 | 64'd13;
        mem_img[root + (((va >> 21) & 64'h1fff) << 3)] = 64'h8000_0000_0000_0000 | l2 | 64'd9;
        mem_img[l2 + (((va >> 12) & 64'h1ff) << 3)] = leaf;
    endtask

    task automatic run_walk(input logic [63:0] va, input logic [31:0] p, input logic [63:0] ptb,
                            input logic pv, fe, st, input bit poke,
                            output logic [4:0] flags, output logic [63:0] ra, output int nreads);
        int waited;
        @(negedge clk);
        ea = va; pid = p; ptbase = ptb; priv = pv; ifetch = fe; store = st;
        start = 1'b1;
        reads = 0;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        flags = 5'h1f;
        ra = '1;
        while (!done && waited < 100) begin
            if (poke && waited == 1) begin
                start = 1'b1; ea = 64'h0000_0001_1111_1000; priv = ~pv; store = ~st;
            end else if (poke && waited == 2) begin
                start = 1'b0;
            end
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        checks++;
        if (!done) begin
            errors++;
            $display("FAIL R11: done missing (actual 0 expected 1)");
        end else begin
            flags = {err_seg, err_badtree, err_invalid, err_perm, err_rc};
            ra = real_addr;
            check64("R11 done one cycle after last ack", 64'(cyc), 64'(ack_cyc + 1));
            nreads = reads;
            @(negedge clk);
            check64("R11 done pulse width", {63'd0, done}, 64'd0);
            check64("R11 flags cleared after done",
                    {59'd0, err_seg, err_badtree, err_invalid, err_perm, err_rc}, 64'd0);
        end
    endtask

    localparam logic [63:0] PTB    = 64'h0000_0000_0001_0000;
    localparam logic [63:0] ROOT   = 64'h0000_0000_0002_0000;
    localparam logic [63:0] L2     = 64'h0000_0000_0003_0000;
    localparam logic [63:0] VA     = 64'h0000_0003_4567_8ABC;
    localparam logic [63:0] GOODLF = 64'hC000_0000_1234_5186;

    initial begin
        logic [4:0]  fl;
        logic [63:0] ra, lf, exp_ra;
        int          nr;

        repeat (3) @(negedge clk);
        check64("R11 reset done", {63'd0, done}, 64'd0);
        check64("R13 reset mem_req", {63'd0, mem_req}, 64'd0);
        check64("R11 reset flags", {59'd0, err_seg, err_badtree, err_invalid, err_perm, err_rc}, 64'd0);
        check64("R11 reset real_addr", real_addr, 64'd0);
        rst_n = 1'b1;

        // R8 R9: sweep of leaf permission bits against access kind
        build_tree(prte_at(PTB, 32'd3), ROOT, L2, VA, GOODLF);
        for (int c = 0; c < 1024; c++) begin
            lf = 64'hC000_0000_1234_5000;
            lf[0] = c[0]; lf[1] = c[1]; lf[2] = c[2]; lf[3] = c[3];
            lf[5] = c[4]; lf[7] = c[5]; lf[8] = c[6];
            mem_img[L2 + (((VA >> 12) & 64'h1ff) << 3)] = lf;
            run_walk(VA, 32'd3, PTB, c[7], c[8], c[9], 1'b0, fl, ra, nr);
            check64("R8 R9 leaf check flags", 64'(fl), 64'(leaf_flags(lf, c[7], c[8], c[9])));
            exp_ra = (leaf_flags(lf, c[7], c[8], c[9]) == F_NONE) ? (lf & 64'h00FF_FFFF_FFFF_FFFF) : 64'd0;
            check64("R10 R11 real address with 4K leaf", ra, exp_ra);
        end

        // R5 R13: standard walk reads three entries
        mem_img[L2 + (((VA >> 12) & 64'h1ff) << 3)] = GOODLF;
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R5 walk result", ra, GOODLF & 64'h00FF_FFFF_FFFF_FFFF);
        check64("R13 read count", 64'(nr), 64'd3);

        // R12: start raised mid-walk is ignored
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b1, fl, ra, nr);
        check64("R12 busy start ignored, address", ra, GOODLF & 64'h00FF_FFFF_FFFF_FFFF);
        check64("R12 busy start ignored, flags", 64'(fl), 64'(F_NONE));
        check64("R12 busy start ignored, reads", 64'(nr), 64'd3);

        // R1: table size code 8 merges PID bits into the base
        build_tree(prte_at(64'h0000_0000_0010_0008, 32'h0001_0205), 64'h0000_0000_0008_0000,
                   64'h0000_0000_0009_0000, VA, 64'hC000_0000_0ABC_D186);
        run_walk(VA, 32'h0001_0205, 64'h0000_0000_0010_0008, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R1 masked-OR table address", ra, 64'h0000_0000_0ABC_D186);

        // R2: ea[63] set selects PID zero
        build_tree(prte_at(PTB, 32'd0), 64'h0000_0000_0004_0000, 64'h0000_0000_0005_0000,
                   64'hC000_0000_0001_2000, 64'hC000_0000_0777_7186);
        run_walk(64'hC000_0000_0001_2000, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R2 zero PID when ea[63] set", ra, 64'h0000_0000_0777_7186);
        check64("R2 flags", 64'(fl), 64'(F_NONE));

        // R3: segment checks
        run_walk(64'h8000_0000_0001_2000, 32'd0, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R3 ea[63]!=ea[62]", 64'(fl), 64'(F_SEG));
        run_walk(VA | (64'd1 << 40), 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R3 bit 40 outside tree", 64'(fl), 64'(F_SEG));
        check64("R11 real zero on fault", ra, 64'd0);
        run_walk(VA | (64'd1 << 34), 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R3 bit 34 just outside tree", 64'(fl), 64'(F_SEG));

        // R4: root size bounds
        mem_img[prte_at(PTB, 32'd7)] = ROOT | 64'h60 | 64'd4;
        run_walk(VA, 32'd7, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R4 root size 4 rejected", 64'(fl), 64'(F_BAD));
        mem_img[prte_at(PTB, 32'd7)] = ROOT | 64'h60 | 64'd17;
        run_walk(VA, 32'd7, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R4 root size 17 rejected", 64'(fl), 64'(F_BAD));

        // R6: level size above remaining shift (9) rejected
        mem_img[ROOT + (((VA >> 21) & 64'h1fff) << 3)] = 64'h8000_0000_0000_0000 | L2 | 64'd10;
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R6 level size over shift", 64'(fl), 64'(F_BAD));

        // R7: invalid directory and invalid leaf
        mem_img[ROOT + (((VA >> 21) & 64'h1fff) << 3)] = L2 | 64'd9;
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R7 invalid directory entry", 64'(fl), 64'(F_INV));
        mem_img[ROOT + (((VA >> 21) & 64'h1fff) << 3)] = 64'h8000_0000_0000_0000 | L2 | 64'd9;
        mem_img[L2 + (((VA >> 12) & 64'h1ff) << 3)] = 64'h4000_0000_1234_5186;
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        check64("R7 invalid leaf entry", 64'(fl), 64'(F_INV));

        // R10: leaf at root level, 9 address bits pass through
        lf = 64'hC000_0000_ABCD_E186;
        mem_img[ROOT + (((VA >> 21) & 64'h1fff) << 3)] = lf;
        run_walk(VA, 32'd3, PTB, 1'b0, 1'b0, 1'b0, 1'b0, fl, ra, nr);
        exp_ra = {8'h00, (lf[55:12] & ~44'h1ff) | (VA[55:12] & 44'h1ff), lf[11:0]};
        check64("R10 large page real address", ra, exp_ra);
        check64("R13 large page read count", 64'(nr), 64'd2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule